// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Delayed External Requests

This block gathers interrupt requests from a chip's peripherals and presents the most urgent one to a processor as a 3-bit, active-low priority code. It keeps a 15-bit pending-request register and a 15-bit enable register. Software changes both over a small write port: bit 15 of the written word chooses between setting and clearing, and bits 14:0 select the bits to change. A readable copy of the pending register is brought out on its own port.

Requests arrive by three routes. On-chip sources pulse a per-bit set vector and the bit is set at the next clock edge. A vertical-strobe input is edge-detected and sets the frame-blank request two cycles after its rising edge. Three external, active-low request pins (priority levels 2, 3 and 6) each have their own falling-edge capture and a fixed-length delay line. An event therefore reaches its pending bit a fixed number of cycles later, and a pin that is low for only one cycle is still recorded. A parameter can make any external pin level-sensitive instead.

The priority code is decoded directly from the two stored registers. A write therefore shows on the output right after the edge that stores it, with no extra stage. Bit 14 of the enable register gates the whole output.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset both registers are zero, the delay lines are empty, `req_rd` reads 0 and `ipl_n` reads 3'b111.
- R2: A write with `wr_sel`=0 targets the pending register and one with `wr_sel`=1 the enable register. When `wr_data[15]`=1, bits 14:0 mark bits to set; when it is 0, they mark bits to clear. `req_rd[15]` always reads 0.
- R3: `ipl_n` is the bitwise inverse of the highest level among bits pending and enabled. The bit-to-level map is: bits 0-2 level 1, bit 3 level 2, bits 4-6 level 3, bits 7-10 level 4, bits 11-12 level 5, bit 13 level 6, bit 14 no level. With nothing qualifying, `ipl_n` is 3'b111.
- R4: When enable bit 14 is clear, `ipl_n` is 3'b111 whatever is pending.
- R5: A falling edge on an external pin first sampled at clock edge E sets its pending bit at edge E+4. The pin-to-bit map is `ext_n[0]`→bit 3, `ext_n[1]`→bit 4, `ext_n[2]`→bit 13.
- R6: Each external pin has its own delay line. A second pin falling two cycles after the first still takes the full four cycles, so `ipl_n` steps to level 3 and then to level 6 two cycles later.
- R7: An external pin held low for a single clock cycle is captured and sets its bit.
- R8: In the default edge mode, a pin held low sets its bit once. If software then clears the bit while the pin stays low, the bit stays clear.
- R9: A rising edge on `vstrobe` first sampled at edge E sets pending bit 5 (level 3) at edge E+2.
- R10: A register write stored at edge E is reflected in `req_rd` and `ipl_n` right after edge E, with no extra cycle.
- R11: If a clear-write of a pending bit and a hardware set of the same bit fall on the same edge, the bit ends up set.
- R12: A 1 on `int_set[b]` sampled at edge E sets pending bit b at edge E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 = pending register, 1 = enable register |
| wr_data | input | 16 | Bit 15 set/clear select, bits 14:0 bit mask |
| int_set | input | 15 | On-chip source set pulses, one per pending bit |
| vstrobe | input | 1 | Vertical strobe, active high |
| ext_n | input | 3 | External request pins, active low (levels 2, 3, 6) |
| req_rd | output | 16 | Readable copy of the pending register |
| ipl_n | output | 3 | Active-low priority level to the processor |

## Verification
The two functions that can land on the same edge are a software clear of a pending bit and the arrival of that bit's delayed external event. The bench counts cycles from a one-cycle pulse on the level-3 pin and issues the clear-write so that it is stored on exactly the fourth edge after the pulse. It then judges at the ports that the bit is still set and that the output shows level 3. A related overlap is also checked: a second pin's delay running while the first pin's delay is still in flight. The bench looks at the output cycle by cycle and requires each step at its own edge.

// File: rtl/irq_pkg.sv
package irq_pkg;

   localparam int unsigned REG_W      = 16;
   localparam int unsigned MASK_W     = REG_W - 1;
   localparam int unsigned NUM_EXT    = 3;
   localparam int unsigned MASTER_BIT = 14;
   localparam int unsigned SETCLR_BIT = 15;
   localparam int unsigned VBLANK_BIT = 5;
   localparam int unsigned TOP_LEVEL_BIT = 13;

   typedef logic [2:0]        lvl_t;
   typedef logic [MASK_W-1:0] mask_t;

   typedef enum logic {
      SEL_PEND   = 1'b0,
      SEL_ENABLE = 1'b1
   } reg_sel_e;

   // pending-bit index fed by each external pin
   function automatic int unsigned ext_bit(input int unsigned idx);
      case (idx)
         0:       return 3;
         1:       return 4;
         default: return 13;
      endcase
   endfunction

   // priority level carried by each pending bit
   function automatic lvl_t bit_level(input int unsigned b);
      if (b <= 2)       return 3'd1;
      else if (b == 3)  return 3'd2;
      else if (b <= 6)  return 3'd3;
      else if (b <= 10) return 3'd4;
      else if (b <= 12) return 3'd5;
      else if (b == 13) return 3'd6;
      else              return 3'd0;
   endfunction

endpackage

// File: rtl/irq_edge_cap.sv
module irq_edge_cap #(
   parameter bit ACT_LOW    = 1'b1,
   parameter bit LEVEL_MODE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic evt
);
   logic act;
   logic act_q;

   assign act = ACT_LOW ? ~pin : pin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= act;
   end

   generate
      if (LEVEL_MODE) begin : g_level
         assign evt = act;
      end else begin : g_edge
         assign evt = act & ~act_q;
      end
   endgenerate

endmodule

// File: rtl/irq_delay_line.sv
module irq_delay_line #(
   parameter int unsigned DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("irq_delay_line: DEPTH must be at least 1");
      end
      if (DEPTH == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= 1'b0;
            else        stage_q <= din;
         end
         assign dout = stage_q;
      end else begin : g_chain
         logic [DEPTH-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[DEPTH-2:0], din};
         end
         assign dout = chain_q[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
   import irq_pkg::*;
(
   input  mask_t pend,
   input  mask_t enab,
   output lvl_t  ipl_n
);
   mask_t live;
   lvl_t  best;

   assign live = pend & enab;

   always_comb begin
      best = 3'd0;
      for (int unsigned b = 0; b <= TOP_LEVEL_BIT; b++) begin
         if (live[b] && (bit_level(b) > best)) best = bit_level(b);
      end
      if (!enab[MASTER_BIT]) best = 3'd0;
   end

   assign ipl_n = ~best;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_pkg::*;
#(
   parameter int unsigned EXT_DELAY      = 4,
   parameter int unsigned VB_DELAY       = 2,
   parameter logic [2:0]  EXT_LEVEL_MASK = 3'b000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        wr_sel,
   input  logic [15:0] wr_data,
   input  logic [14:0] int_set,
   input  logic        vstrobe,
   input  logic [2:0]  ext_n,
   output logic [15:0] req_rd,
   output logic [2:0]  ipl_n
);
   localparam int unsigned VB_STAGES = VB_DELAY;

   generate
      if (EXT_DELAY < 1) begin : g_bad_ext
         $error("irq_prio_ctrl: EXT_DELAY must be at least 1");
      end
      if (VB_DELAY < 1) begin : g_bad_vb
         $error("irq_prio_ctrl: VB_DELAY must be at least 1");
      end
      if (REG_W != 16) begin : g_bad_w
         $error("irq_prio_ctrl: register width must be 16");
      end
   endgenerate

   mask_t req_q, en_q;
   mask_t req_w, en_w, req_d;
   mask_t hw_set, ext_hits;
   mask_t wr_mask;
   logic  wr_set;
   logic [NUM_EXT-1:0] ext_evt, ext_late;
   logic  vb_evt, vb_late;

   // per-pin capture and delay
   generate
      for (genvar gi = 0; gi < NUM_EXT; gi++) begin : g_ext
         irq_edge_cap #(
            .ACT_LOW    (1'b1),
            .LEVEL_MODE (EXT_LEVEL_MASK[gi])
         ) u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (ext_n[gi]),
            .evt   (ext_evt[gi])
         );
         irq_delay_line #(.DEPTH(EXT_DELAY)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (ext_evt[gi]),
            .dout  (ext_late[gi])
         );
      end
   endgenerate

   // vertical strobe: rising edge then short delay
   irq_edge_cap #(.ACT_LOW(1'b0), .LEVEL_MODE(1'b0)) u_vb_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (vstrobe),
      .evt   (vb_evt)
   );
   irq_delay_line #(.DEPTH(VB_STAGES - 1 + 1)) u_vb_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (vb_evt),
      .dout  (vb_late)
   );

   always_comb begin
      ext_hits = '0;
      for (int unsigned i = 0; i < NUM_EXT; i++) begin
         ext_hits[ext_bit(i)] = ext_late[i];
      end
      ext_hits[VBLANK_BIT] = ext_hits[VBLANK_BIT] | vb_late;
   end

   assign hw_set  = int_set | ext_hits;
   assign wr_mask = wr_data[MASK_W-1:0];
   assign wr_set  = wr_data[SETCLR_BIT];

   always_comb begin
      req_w = req_q;
      en_w  = en_q;
      if (wr_en) begin
         if (reg_sel_e'(wr_sel) == SEL_PEND) begin
            req_w = wr_set ? (req_q | wr_mask) : (req_q & ~wr_mask);
         end else begin
            en_w  = wr_set ? (en_q | wr_mask) : (en_q & ~wr_mask);
         end
      end
      // hardware sets are applied after software, so they win
      req_d = req_w | hw_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
         en_q  <= '0;
      end else begin
         req_q <= req_d;
         en_q  <= en_w;
      end
   end

   irq_level_enc u_enc (
      .pend  (req_q),
      .enab  (en_q),
      .ipl_n (ipl_n)
   );

   assign req_rd = {1'b0, req_q};

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        wr_sel,
   input logic [15:0] wr_data,
   input logic [14:0] int_set,
   input logic        vstrobe,
   input logic [15:0] req_rd,
   input logic [2:0]  ipl_n,
   input logic [14:0] en_q
);
   logic vs_prev, vs_e1, vs_e2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_prev <= 1'b0;
         vs_e1   <= 1'b0;
         vs_e2   <= 1'b0;
      end else begin
         vs_prev <= vstrobe;
         vs_e1   <= vstrobe & ~vs_prev;
         vs_e2   <= vs_e1;
      end
   end

   // R4
   a_r4_master_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[14] |-> ipl_n == 3'b111);

   // R3
   a_r3_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_rd[13:0] & en_q[13:0]) == 14'd0) |-> ipl_n == 3'b111);

   // R3
   a_r3_top_level: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[14] && req_rd[13] && en_q[13]) |-> ipl_n == 3'b001);

   // R2
   a_r2_set_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && wr_data[15]) |=>
         ((req_rd[14:0] & $past(wr_data[14:0])) == $past(wr_data[14:0])));

   // R2
   a_r2_rd_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
      req_rd[15] == 1'b0);

   // R12
   a_r12_int_set: assert property (@(posedge clk) disable iff (!rst_n)
      (int_set != 15'd0) |=> ((req_rd[14:0] & $past(int_set)) == $past(int_set)));

   // R9
   a_r9_vblank_delay: assert property (@(posedge clk) disable iff (!rst_n)
      vs_e2 |=> req_rd[5]);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .wr_data (wr_data),
   .int_set (int_set),
   .vstrobe (vstrobe),
   .req_rd  (req_rd),
   .ipl_n   (ipl_n),
   .en_q    (en_q)
);

// File: tb/irq_prio_ctrl_tb_top.sv
module irq_prio_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic [14:0] int_set = '0;
   logic        vstrobe = 1'b0;
   logic [2:0]  ext_n = 3'b111;
   logic [15:0] req_rd;
   logic [2:0]  ipl_n;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   irq_prio_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .int_set(int_set), .vstrobe(vstrobe),
      .ext_n(ext_n), .req_rd(req_rd), .ipl_n(ipl_n)
   );

   // {sel, data, expected req_rd, expected ipl_n}
   localparam int NV = 10;
   localparam logic [35:0] VEC [NV] = '{
      {1'b0, 16'h8001, 16'h0001, 3'b111},
      {1'b1, 16'hC001, 16'h0001, 3'b110},
      {1'b0, 16'h8080, 16'h0081, 3'b110},
      {1'b1, 16'h8080, 16'h0081, 3'b011},
      {1'b1, 16'h4000, 16'h0081, 3'b111},
      {1'b1, 16'hC000, 16'h0081, 3'b011},
      {1'b0, 16'h0080, 16'h0001, 3'b110},
      {1'b0, 16'hA000, 16'h2001, 3'b110},
      {1'b1, 16'hA000, 16'h2001, 3'b001},
      {1'b0, 16'h7FFF, 16'h0000, 3'b111}
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic sel, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(10 * 200000);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad + 1 - 1, n_chk + 1);
      $finish;
   end

   initial begin
      tick(3);
      // R1 reset state
      chk("R1 req_rd", req_rd, 16'h0000);
      chk("R1 ipl_n", {13'd0, ipl_n}, 16'h0007);
      rst_n = 1'b1;
      tick(2);
      chk("R1 after release", {13'd0, ipl_n}, 16'h0007);

      // R2 R3 R4 R10 table, each checked one edge after the write
      for (int v = 0; v < NV; v++) begin
         do_write(VEC[v][35], VEC[v][34:19]);
         chk($sformatf("R2/R10 vec%0d req", v), req_rd, VEC[v][18:3]);
         chk($sformatf("R3/R4 vec%0d ipl", v), {13'd0, ipl_n}, {13'd0, VEC[v][2:0]});
      end

      do_write(1'b1, 16'hFFFF);   // enable everything

      // R5 R7: one-cycle pulse on level-3 pin, set on fourth edge
      @(negedge clk); ext_n[1] = 1'b0;
      @(negedge clk); ext_n[1] = 1'b1;   // edge E passed
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         chk($sformatf("R5 early E+%0d", k), req_rd, 16'h0000);
      end
      @(negedge clk);
      chk("R7 pulse caught bit4", req_rd, 16'h0010);
      chk("R5 ipl level3", {13'd0, ipl_n}, 16'h0004);
      do_write(1'b0, 16'h7FFF);

      // R6: second pin two cycles later keeps its own full delay
      @(negedge clk); ext_n[1] = 1'b0;
      @(negedge clk); ext_n[1] = 1'b1;   // after E
      @(negedge clk); ext_n[2] = 1'b0;   // sampled at E+2
      tick(2);                           // after E+3
      chk("R6 E+3 idle", {13'd0, ipl_n}, 16'h0007);
      tick(1);
      chk("R6 E+4 level3", {13'd0, ipl_n}, 16'h0004);
      tick(1);
      chk("R6 E+5 still level3", {13'd0, ipl_n}, 16'h0004);
      tick(1);
      chk("R6 E+6 level6", {13'd0, ipl_n}, 16'h0001);
      chk("R6 both bits", req_rd, 16'h2010);
      ext_n[2] = 1'b1;
      do_write(1'b0, 16'h7FFF);

      // R8: held-low level-2 pin sets once
      @(negedge clk); ext_n[0] = 1'b0;
      tick(6);
      chk("R8 held sets bit3", req_rd, 16'h0008);
      chk("R8 ipl level2", {13'd0, ipl_n}, 16'h0005);
      do_write(1'b0, 16'h0008);
      tick(6);
      chk("R8 no re-set while low", req_rd, 16'h0000);
      chk("R8 ipl idle", {13'd0, ipl_n}, 16'h0007);
      ext_n[0] = 1'b1;
      tick(2);

      // R9: vertical strobe, two-cycle delay
      @(negedge clk); vstrobe = 1'b1;
      @(negedge clk);                    // after E
      chk("R9 E early", req_rd, 16'h0000);
      @(negedge clk);
      chk("R9 E+1 early", req_rd, 16'h0000);
      @(negedge clk);
      chk("R9 E+2 bit5", req_rd, 16'h0020);
      chk("R9 ipl level3", {13'd0, ipl_n}, 16'h0004);
      vstrobe = 1'b0;
      do_write(1'b0, 16'h7FFF);

      // R12: on-chip source bit 11 (level 5)
      @(negedge clk); int_set = 15'h0800;
      @(negedge clk); int_set = '0;
      chk("R12 bit11 set", req_rd, 16'h0800);
      chk("R12 ipl level5", {13'd0, ipl_n}, 16'h0002);
      do_write(1'b0, 16'h7FFF);

      // R11: clear-write on the same edge as the delayed arrival
      @(negedge clk); ext_n[1] = 1'b0;
      @(negedge clk); ext_n[1] = 1'b1;   // after E
      tick(2);                           // after E+2
      @(negedge clk);                    // after E+3
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h0010;
      @(negedge clk);                    // after E+4
      wr_en = 1'b0;
      chk("R11 set wins over clear", req_rd, 16'h0010);
      chk("R11 ipl level3", {13'd0, ipl_n}, 16'h0004);
      do_write(1'b0, 16'h0010);
      chk("R11 later clear works", req_rd, 16'h0000);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule